// File: doc/BRIEF.md
# IDE Bus-Master Sector Transfer Sequencer

This block sits between a descriptor-driven DMA engine and a sector-addressed storage back end. When the DMA engine starts a transfer, the block takes the descriptor it presents (buffer address and byte length). It turns the whole remaining length into one storage request at the drive's current position. When that request completes, it updates the drive position and the remaining work. It then tells the DMA engine that the descriptor is used up. Only one storage request is outstanding at any time.

The same engine serves two drive types. In disk mode, positions are 512-byte sectors. A completed chunk is rounded up to whole sectors. The sector address moves forward and a sector countdown moves down. When the countdown reaches zero, the drive reports ready with seek complete and raises its interrupt. In optical mode, the drive tracks a 2048-byte logical block plus a byte offset inside it. Each request is addressed in 512-byte units derived from both. A signed packet byte count is decremented, and a command-success pulse fires once that count is at or below zero. Optical mode only reads.

The position and count registers are loaded by a command strobe while the block is idle. A storage error ends the DMA with an error pulse that depends on the mode. An optical launch with no medium present ends the DMA with a not-ready pulse.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `req_valid_o`, `irq_o`, `drive_ready_o` and all pulse outputs are 0, and no request is issued while idle.
- R2: On a start, the in-flight size is cleared, so the first completion pass does no accounting. If the descriptor length L is nonzero, exactly one request is issued with `req_len_o`=L. `desc_addr_o` then reads the start address plus L.
- R3: Disk mode. The request address equals the current sector. After a successful chunk of N bytes, `sector_o` increases by (N+511)>>9 and `count_o` decreases by the same amount, both modulo their widths.
- R4: Disk mode. Whenever a completion pass finds `count_o` at zero (including the first pass), `drive_ready_o` and `irq_o` become 1. They stay 1 until the next load strobe.
- R5: Each DMA ends with exactly one single-cycle `dma_end_o` pulse. A start with zero length pulses `dma_end_o` and issues no request.
- R6: `req_write_o` equals the direction input latched at start in disk mode, and is always 0 in optical mode.
- R7: Optical mode. After a successful chunk of N bytes, the byte index becomes idx+N. The block address then increases by (idx+N)>>11, and the index keeps (idx+N) mod 2048.
- R8: Optical mode. The signed packet count decreases by N per successful chunk. `cmd_ok_o` pulses on every completion pass that finds the count ≤ 0.
- R9: Optical mode. The request address in 512-byte units is block*4 + (index>>9), truncated to the sector width.
- R10: A storage completion with error does no accounting. It ends the DMA, pulsing `dma_err_o` in disk mode or `io_err_o` in optical mode, together with `dma_end_o`.
- R11: Optical mode with `media_present_i`=0 at launch issues no request. It pulses `not_ready_o` together with `dma_end_o`.
- R12: A request, once valid, holds its fields stable until accepted. No second request is issued before the first one's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_load_i | input | 1 | Load position/count registers (idle only) |
| load_sector_i | input | SECT_W | Initial sector (disk) or logical block (optical) |
| load_count_i | input | CNT_W | Initial sector countdown |
| load_pkt_i | input | PKT_W | Initial packet byte count (signed) |
| start_i | input | 1 | Start a DMA (idle only) |
| mode_optical_i | input | 1 | 1 = optical packet mode, 0 = disk mode |
| dir_write_i | input | 1 | Disk direction, 1 = write to storage |
| media_present_i | input | 1 | Medium present for optical launches |
| desc_addr_i | input | ADDR_W | Descriptor buffer address |
| desc_len_i | input | LEN_W | Descriptor byte length |
| desc_addr_o | output | ADDR_W | Descriptor address after consumption |
| dma_end_o | output | 1 | Descriptor finished pulse |
| busy_o | output | 1 | DMA in progress |
| req_valid_o | output | 1 | Storage request valid |
| req_ready_i | input | 1 | Storage request accepted |
| req_addr_o | output | SECT_W | Request address in 512-byte units |
| req_len_o | output | LEN_W | Request byte length |
| req_write_o | output | 1 | Request is a write |
| done_i | input | 1 | Storage completion pulse |
| done_err_i | input | 1 | Completion carries an error |
| sector_o | output | SECT_W | Current sector or logical block |
| count_o | output | CNT_W | Remaining sectors (disk) |
| byte_idx_o | output | 11 | Byte offset inside logical block (optical) |
| pkt_left_o | output | PKT_W | Remaining packet bytes, signed (optical) |
| drive_ready_o | output | 1 | Ready plus seek-complete status |
| irq_o | output | 1 | Drive interrupt |
| cmd_ok_o | output | 1 | Optical command success pulse |
| dma_err_o | output | 1 | Disk DMA error pulse |
| io_err_o | output | 1 | Optical I/O error pulse |
| not_ready_o | output | 1 | Not-ready / medium-absent pulse |

## Verification
The bench builds the block with a 12-bit length, 16-bit sector and address fields, an 8-bit sector countdown and a 16-bit packet count. With these widths, lengths just below, at and just above a sector boundary, and up to the 4095-byte maximum, are all reachable. A short sequence of disk chunks drives the countdown exactly to zero. Optical chunk series cross block boundaries, including a carry of the byte index. They also drive the packet count from positive to negative, which makes every success-pulse pass observable. Error completions, zero-length descriptors and medium-absent launches are interleaved in both modes, so the no-accounting paths are checked against an unchanged model.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCT,
    ST_REQ,
    ST_WAIT
  } seq_state_e;

  localparam int unsigned SECT_SHIFT = 9;
  localparam int unsigned BLK_SHIFT  = 11;
endpackage

// File: rtl/ide_disk_acct.sv
module ide_disk_acct #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned SECT_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic [SECT_W-1:0] sector_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [LEN_W-1:0]  bytes_i,
  output logic [SECT_W-1:0] sector_o,
  output logic [CNT_W-1:0]  count_o
);
  import ide_dma_pkg::*;
  localparam int unsigned UP_W = LEN_W + 1;

  logic [UP_W-1:0] up_bytes;
  logic [UP_W-1:0] nsect;

  always_comb begin
    up_bytes = UP_W'(bytes_i) + UP_W'((1 << SECT_SHIFT) - 1);
    nsect    = up_bytes >> SECT_SHIFT;
    sector_o = sector_i + SECT_W'(nsect);
    count_o  = count_i - CNT_W'(nsect);
  end
endmodule

// File: rtl/ide_optical_acct.sv
module ide_optical_acct #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned SECT_W = 32,
  parameter int unsigned PKT_W  = 24
) (
  input  logic [SECT_W-1:0] lba_i,
  input  logic [10:0]       idx_i,
  input  logic [PKT_W-1:0]  pkt_i,
  input  logic [LEN_W-1:0]  bytes_i,
  output logic [SECT_W-1:0] lba_o,
  output logic [10:0]       idx_o,
  output logic [PKT_W-1:0]  pkt_o
);
  import ide_dma_pkg::*;
  localparam int unsigned SUM_W = ((LEN_W > 11) ? LEN_W : 11) + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum   = SUM_W'(idx_i) + SUM_W'(bytes_i);
    idx_o = sum[10:0];
    lba_o = lba_i + SECT_W'(sum >> BLK_SHIFT);
    pkt_o = pkt_i - PKT_W'(bytes_i);
  end
endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned SECT_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PKT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_load_i,
  input  logic [SECT_W-1:0] load_sector_i,
  input  logic [CNT_W-1:0]  load_count_i,
  input  logic [PKT_W-1:0]  load_pkt_i,
  input  logic              start_i,
  input  logic              mode_optical_i,
  input  logic              dir_write_i,
  input  logic              media_present_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic              dma_end_o,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [SECT_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              req_write_o,
  input  logic              done_i,
  input  logic              done_err_i,
  output logic [SECT_W-1:0] sector_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [10:0]       byte_idx_o,
  output logic [PKT_W-1:0]  pkt_left_o,
  output logic              drive_ready_o,
  output logic              irq_o,
  output logic              cmd_ok_o,
  output logic              dma_err_o,
  output logic              io_err_o,
  output logic              not_ready_o
);
  import ide_dma_pkg::*;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] daddr_q;
  logic [LEN_W-1:0]  dlen_q, buf_q;
  logic              opt_q, wr_q;
  logic [SECT_W-1:0] sector_q, raddr_q;
  logic [CNT_W-1:0]  count_q;
  logic [10:0]       idx_q;
  logic [PKT_W-1:0]  pkt_q;
  logic              rdy_q, irq_q;
  logic              end_q, ok_q, derr_q, ioerr_q, nrdy_q;

  logic [SECT_W-1:0] dsec_nx, olba_nx, sec_eff;
  logic [CNT_W-1:0]  dcnt_nx, cnt_eff;
  logic [10:0]       oidx_nx, idx_eff;
  logic [PKT_W-1:0]  opkt_nx, pkt_eff;
  logic              acct, disk_zero, pkt_done, no_media;
  logic [SECT_W-1:0] launch_addr;

  ide_disk_acct #(.LEN_W(LEN_W), .SECT_W(SECT_W), .CNT_W(CNT_W)) disk_acct_i (
    .sector_i(sector_q), .count_i(count_q), .bytes_i(buf_q),
    .sector_o(dsec_nx), .count_o(dcnt_nx)
  );

  ide_optical_acct #(.LEN_W(LEN_W), .SECT_W(SECT_W), .PKT_W(PKT_W)) opt_acct_i (
    .lba_i(sector_q), .idx_i(idx_q), .pkt_i(pkt_q), .bytes_i(buf_q),
    .lba_o(olba_nx), .idx_o(oidx_nx), .pkt_o(opkt_nx)
  );

  // values after this pass's accounting (none on the first pass)
  always_comb begin
    acct    = (buf_q != '0);
    sec_eff = sector_q;
    cnt_eff = count_q;
    idx_eff = idx_q;
    pkt_eff = pkt_q;
    if (acct && !opt_q) begin
      sec_eff = dsec_nx;
      cnt_eff = dcnt_nx;
    end else if (acct) begin
      sec_eff = olba_nx;
      idx_eff = oidx_nx;
      pkt_eff = opkt_nx;
    end
    disk_zero = !opt_q && (cnt_eff == '0);
    pkt_done  = opt_q && (pkt_eff[PKT_W-1] || (pkt_eff == '0));
    no_media  = opt_q && !media_present_i;
    launch_addr = opt_q ? SECT_W'({sec_eff, 2'b00} + (SECT_W+2)'(idx_eff >> SECT_SHIFT))
                        : sec_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      daddr_q  <= '0;
      dlen_q   <= '0;
      buf_q    <= '0;
      opt_q    <= 1'b0;
      wr_q     <= 1'b0;
      sector_q <= '0;
      raddr_q  <= '0;
      count_q  <= '0;
      idx_q    <= '0;
      pkt_q    <= '0;
      rdy_q    <= 1'b0;
      irq_q    <= 1'b0;
      end_q    <= 1'b0;
      ok_q     <= 1'b0;
      derr_q   <= 1'b0;
      ioerr_q  <= 1'b0;
      nrdy_q   <= 1'b0;
    end else begin
      end_q   <= 1'b0;
      ok_q    <= 1'b0;
      derr_q  <= 1'b0;
      ioerr_q <= 1'b0;
      nrdy_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_load_i) begin
            sector_q <= load_sector_i;
            count_q  <= load_count_i;
            pkt_q    <= load_pkt_i;
            idx_q    <= '0;
            rdy_q    <= 1'b0;
            irq_q    <= 1'b0;
          end else if (start_i) begin
            opt_q   <= mode_optical_i;
            wr_q    <= dir_write_i;
            daddr_q <= desc_addr_i;
            dlen_q  <= desc_len_i;
            buf_q   <= '0;
            state_q <= ST_ACCT;
          end
        end
        ST_ACCT: begin
          sector_q <= sec_eff;
          count_q  <= cnt_eff;
          idx_q    <= idx_eff;
          pkt_q    <= pkt_eff;
          if (disk_zero) begin
            rdy_q <= 1'b1;
            irq_q <= 1'b1;
          end
          ok_q <= pkt_done;
          if (dlen_q == '0) begin
            end_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            daddr_q <= daddr_q + ADDR_W'(dlen_q);
            dlen_q  <= '0;
            buf_q   <= dlen_q;
            if (no_media) begin
              nrdy_q  <= 1'b1;
              end_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              raddr_q <= launch_addr;
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (done_i && done_err_i) begin
            derr_q  <= !opt_q;
            ioerr_q <= opt_q;
            end_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (done_i) begin
            state_q <= ST_ACCT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign desc_addr_o   = daddr_q;
  assign dma_end_o     = end_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign req_valid_o   = (state_q == ST_REQ);
  assign req_addr_o    = raddr_q;
  assign req_len_o     = buf_q;
  assign req_write_o   = wr_q && !opt_q;
  assign sector_o      = sector_q;
  assign count_o       = count_q;
  assign byte_idx_o    = idx_q;
  assign pkt_left_o    = pkt_q;
  assign drive_ready_o = rdy_q;
  assign irq_o         = irq_q;
  assign cmd_ok_o      = ok_q;
  assign dma_err_o     = derr_q;
  assign io_err_o      = ioerr_q;
  assign not_ready_o   = nrdy_q;
endmodule

// File: rtl/ide_dma_seq_chk.sv
module ide_dma_seq_chk #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned SECT_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mode_optical_i,
  input logic              busy_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [SECT_W-1:0] req_addr_o,
  input logic [LEN_W-1:0]  req_len_o,
  input logic              req_write_o,
  input logic              done_i,
  input logic              dma_end_o,
  input logic              dma_err_o,
  input logic              io_err_o,
  input logic              not_ready_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  count_o
);
  logic mode_q;
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      outst_q <= 1'b0;
    end else begin
      if (start_i && !busy_o) mode_q <= mode_optical_i;
      if (req_valid_o && req_ready_i) outst_q <= 1'b1;
      else if (done_i) outst_q <= 1'b0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));

  // R12
  single_outst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !req_valid_o);

  // R5
  end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_end_o |=> !dma_end_o);

  // R6
  opt_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && mode_q) |-> !req_write_o);

  // R10
  err_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_err_o || io_err_o) |-> (dma_end_o && !(dma_err_o && io_err_o)));

  // R11
  nomedia_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_ready_o |-> (dma_end_o && mode_q && !req_valid_o));

  // R4
  irq_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (count_o == '0));
endmodule

bind ide_dma_seq ide_dma_seq_chk #(.LEN_W(LEN_W), .SECT_W(SECT_W), .CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_optical_i(mode_optical_i),
  .busy_o(busy_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_addr_o(req_addr_o), .req_len_o(req_len_o), .req_write_o(req_write_o),
  .done_i(done_i), .dma_end_o(dma_end_o), .dma_err_o(dma_err_o), .io_err_o(io_err_o),
  .not_ready_o(not_ready_o), .irq_o(irq_o), .count_o(count_o)
);

// File: tb/ide_dma_seq_tb_top.sv
module ide_dma_seq_tb_top;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned LEN_W  = 12;
  localparam int unsigned SECT_W = 16;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned PKT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              cmd_load = 0, start = 0, mode_opt = 0, dir_wr = 0, media = 1;
  logic [SECT_W-1:0] ld_sec = '0;
  logic [CNT_W-1:0]  ld_cnt = '0;
  logic [PKT_W-1:0]  ld_pkt = '0;
  logic [ADDR_W-1:0] d_addr = '0;
  logic [LEN_W-1:0]  d_len = '0;
  logic              req_ready = 0, done = 0, done_err = 0;
  logic [ADDR_W-1:0] desc_addr_o;
  logic              dma_end, busy, req_valid, req_write;
  logic [SECT_W-1:0] req_addr, sector;
  logic [LEN_W-1:0]  req_len;
  logic [CNT_W-1:0]  count;
  logic [10:0]       bidx;
  logic [PKT_W-1:0]  pkt_left;
  logic              drdy, irq, cmd_ok, dma_err, io_err, nrdy;

  ide_dma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECT_W(SECT_W), .CNT_W(CNT_W), .PKT_W(PKT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_load_i(cmd_load), .load_sector_i(ld_sec),
    .load_count_i(ld_cnt), .load_pkt_i(ld_pkt), .start_i(start), .mode_optical_i(mode_opt),
    .dir_write_i(dir_wr), .media_present_i(media), .desc_addr_i(d_addr), .desc_len_i(d_len),
    .desc_addr_o(desc_addr_o), .dma_end_o(dma_end), .busy_o(busy), .req_valid_o(req_valid),
    .req_ready_i(req_ready), .req_addr_o(req_addr), .req_len_o(req_len), .req_write_o(req_write),
    .done_i(done), .done_err_i(done_err), .sector_o(sector), .count_o(count), .byte_idx_o(bidx),
    .pkt_left_o(pkt_left), .drive_ready_o(drdy), .irq_o(irq), .cmd_ok_o(cmd_ok),
    .dma_err_o(dma_err), .io_err_o(io_err), .not_ready_o(nrdy)
  );

  int n_chk = 0, n_bad = 0;
  int c_end = 0, c_ok = 0, c_derr = 0, c_ioerr = 0, c_nrdy = 0;

  always @(posedge clk) begin
    if (dma_end) c_end++;
    if (cmd_ok)  c_ok++;
    if (dma_err) c_derr++;
    if (io_err)  c_ioerr++;
    if (nrdy)    c_nrdy++;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model state
  int m_sec, m_cnt, m_lba, m_idx, m_pkt, m_irq;
  int e_end, e_ok, e_derr, e_ioerr, e_nrdy;
  int cur_addr = 16'h1000;

  bit got_req;
  int r_addr, r_len, r_wr;

  task automatic run_dma(input bit opt, input bit wr, input int len, input bit err, input bit med);
    int ends0;
    @(negedge clk);
    start = 1; mode_opt = opt; dir_wr = wr; media = med;
    d_addr = ADDR_W'(cur_addr); d_len = LEN_W'(len);
    @(negedge clk);
    start = 0;
    ends0 = c_end;
    got_req = 0;
    for (int k = 0; k < 60 && c_end == ends0; k++) begin
      if (req_valid && !got_req) begin
        got_req = 1;
        r_addr = int'(req_addr); r_len = int'(req_len); r_wr = int'(req_write);
        repeat (2) @(negedge clk);   // hold ready off to exercise stall
        req_ready = 1;
        @(negedge clk);
        req_ready = 0;
        repeat (3) @(negedge clk);
        done = 1; done_err = err;
        @(negedge clk);
        done = 0; done_err = 0;
      end else begin
        @(negedge clk);
      end
    end
    if (c_end == ends0) begin
      n_chk++; n_bad++;
      $display("FAIL R5: actual no dma_end expected dma_end");
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic common_checks(input int len);
    check("R2 desc_addr", int'(desc_addr_o), (len != 0) ? ((cur_addr + len) & 16'hFFFF) : cur_addr);
    check("R5 end count", c_end, e_end);
    check("R10 dma_err count", c_derr, e_derr);
    check("R10 io_err count", c_ioerr, e_ioerr);
    check("R11 not_ready count", c_nrdy, e_nrdy);
    check("R8 cmd_ok count", c_ok, e_ok);
    check("R1 idle after end", int'(busy), 0);
    cur_addr = (cur_addr + 16'h0100) & 16'hFFFF;
  endtask

  task automatic disk_case(input bit wr, input int len, input bit err);
    int n;
    n = (len + 511) >> 9;
    if (m_cnt == 0) m_irq = 1;
    e_end++;
    run_dma(0, wr, len, err, 1);
    if (len != 0) begin
      check("R2 request issued", int'(got_req), 1);
      check("R3 req addr", r_addr, m_sec);
      check("R2 req len", r_len, len);
      check("R6 disk dir", r_wr, int'(wr));
      if (!err) begin
        m_sec = (m_sec + n) & 16'hFFFF;
        m_cnt = (m_cnt - n) & 8'hFF;
        if (m_cnt == 0) m_irq = 1;
      end else e_derr++;
    end else begin
      check("R5 no request on zero len", int'(got_req), 0);
    end
    check("R3 sector", int'(sector), m_sec);
    check("R3 count", int'(count), m_cnt);
    check("R4 irq", int'(irq), m_irq);
    check("R4 drive_ready", int'(drdy), m_irq);
    common_checks(len);
  endtask

  task automatic opt_case(input int len, input bit err, input bit med);
    if (m_pkt <= 0) e_ok++;
    e_end++;
    run_dma(1, 1, len, err, med);
    if (len != 0 && !med) begin
      e_nrdy++;
      check("R11 no request without medium", int'(got_req), 0);
    end else if (len != 0) begin
      check("R2 request issued", int'(got_req), 1);
      check("R9 req addr", r_addr, (m_lba * 4 + (m_idx >> 9)) & 16'hFFFF);
      check("R2 req len", r_len, len);
      check("R6 optical read only", r_wr, 0);
      if (!err) begin
        m_idx = m_idx + len;
        m_lba = (m_lba + (m_idx >> 11)) & 16'hFFFF;
        m_idx = m_idx & 2047;
        m_pkt = m_pkt - len;
        if (m_pkt <= 0) e_ok++;
      end else e_ioerr++;
    end else begin
      check("R5 no request on zero len", int'(got_req), 0);
    end
    check("R7 lba", int'(sector), m_lba);
    check("R7 byte index", int'(bidx), m_idx);
    check("R8 packet left", int'($signed(pkt_left)), m_pkt);
    common_checks(len);
  endtask

  task automatic load(input int sec, input int cnt, input int pkt);
    @(negedge clk);
    cmd_load = 1; ld_sec = SECT_W'(sec); ld_cnt = CNT_W'(cnt); ld_pkt = PKT_W'(pkt);
    @(negedge clk);
    cmd_load = 0;
    m_sec = sec; m_cnt = cnt; m_lba = sec; m_idx = 0; m_pkt = pkt; m_irq = 0;
  endtask

  initial begin
    e_end = 0; e_ok = 0; e_derr = 0; e_ioerr = 0; e_nrdy = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 req_valid", int'(req_valid), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 drive_ready", int'(drdy), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", int'(req_valid), 0);

    // disk sweep: 12 sectors consumed by 1,2,1,2,3,3
    load(16'h1230, 12, 0);
    disk_case(0, 512, 0);
    disk_case(0, 513, 0);
    disk_case(1, 1, 0);
    disk_case(0, 1024, 0);
    disk_case(0, 0, 0);
    disk_case(1, 700, 1);
    disk_case(1, 1500, 0);
    disk_case(0, 1536, 0);
    disk_case(0, 0, 0);
    disk_case(1, 4095, 0);
    // wraparound of sector address
    load(16'hFFFE, 3, 0);
    disk_case(0, 1025, 0);
    load(16'h0040, 0, 0);
    disk_case(1, 0, 0);

    // optical sweep
    load(100, 0, 5000);
    opt_case(700, 0, 1);
    opt_case(1400, 0, 1);
    opt_case(512, 1, 1);
    opt_case(300, 0, 0);
    opt_case(2048, 0, 1);
    opt_case(1535, 0, 1);
    opt_case(0, 0, 1);
    opt_case(4095, 0, 1);
    load(7, 0, 2048);
    for (int i = 1; i <= 4; i++) opt_case(i * 511, 0, 1);
    opt_case(0, 0, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R5: actual watchdog expired expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule